// File: doc/BRIEF.md
# Multicycle Control Sequencer with Interrupt Entry

This block is the control unit of a small 8-bit accumulator processor. It presents a program address to an external instruction ROM and latches the 17-bit word that comes back. Each instruction then passes through a fixed run of phases: fetch, decode, execute and a settle phase. The datapath (ALU, accumulators, data RAM, ports) sits outside. It decodes the latched word that this block exports, and it acts only while this block holds its datapath enable high. That enable is raised one phase early, in decode, and held through execute.

The sequencer owns the program counter, an eight-entry return stack, the global interrupt enable and a one-bit shadow of the carry flag. Branches, calls, returns, a table-style relative jump and the interrupt enable controls are carried out here without datapath help. A request on the interrupt line is sampled only at the end of the settle phase. When it is taken, the return address is pushed and carry is captured in one phase, and the program counter is forced to a fixed vector in the next. The matching return-from-interrupt gives the captured carry back to the datapath.

Top module: `mcs_sequencer`

## Requirements
- R1: While `rst_n` is low, `ctl_state` is 0 (reset phase), `rom_addr` is 0, `acc_clr` is 1, and `int_en` and `stk_err` are 0. After `rst_n` rises the reset phase lasts two clocks, then fetch (`ctl_state`=1) begins at address 0.
- R2: Every instruction runs fetch(1), decode(2), execute(3), wait(4), one clock each. `ir_load` is high only in fetch. The word on `instr_word` is captured as `ir_q`, and the program counter advances by one, modulo `ROM_DEPTH`, at the end of fetch.
- R3: Word layout: opcode bits [16:12], general field bits [11:4], then addressing [3:2], source [1] and destination [0]. `dp_en` is high in both decode and execute, and only there, when the 5-bit opcode has bit 4 clear or equals 11000, 11010 or 11011. For all other opcodes it stays low.
- R4: Opcode bits [16:13] = 1000 loads the program counter from target bits [12:0] (truncated to the address width) when `zero_flag` is high during execute. Otherwise execution falls through. Opcode 1001 does the same on `carry_flag`.
- R5: Opcode 1010 always loads the target.
- R6: Opcode 1011 pushes the address of the following instruction and loads the target. Opcode 11001 pops the stack into the program counter.
- R7: Opcode 11111 sets the program counter to the following instruction's address plus the unsigned general field, modulo `ROM_DEPTH`.
- R8: Opcode 11100 sets `int_en` at the end of execute, and opcode 11101 clears it.
- R9: At the end of wait, `irq_req` high with `int_en` high moves to interrupt (5), then interrupt-jump (6), then fetch at `INT_VEC`. The interrupt phase pushes the next instruction's address and clears `int_en`. If `int_en` is low, `irq_req` has no effect.
- R10: The interrupt phase captures `carry_flag`. Opcode 11110 pops the return address, sets `int_en`, and in its execute phase drives `carry_wr_en` high with the captured value on `carry_wr_val`.
- R11: The stack holds 8 entries with a wrapping pointer. A ninth outstanding push, or a pop from an empty stack, sets the sticky `stk_err`, which only reset clears. After nine calls, a return yields the ninth return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request level |
| instr_word | input | 17 | Word read from program ROM at `rom_addr` |
| zero_flag | input | 1 | Zero flag from the ALU |
| carry_flag | input | 1 | Carry flag from the ALU |
| rom_addr | output | PC_W | Program counter / ROM address |
| ir_q | output | 17 | Latched instruction for datapath decode |
| ir_load | output | 1 | High in fetch |
| dp_en | output | 1 | Datapath action enable (decode and execute) |
| acc_clr | output | 1 | Clear accumulators (reset phase) |
| carry_wr_en | output | 1 | Restore carry from shadow |
| carry_wr_val | output | 1 | Shadowed carry value |
| int_en | output | 1 | Global interrupt enable |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |
| ctl_state | output | 3 | Current phase code |

## Verification
The assertions assume that the ROM returns the word for `rom_addr` combinationally, within the fetch phase. They also assume that the flags are settled during execute, and that reset is held low for at least one clock before the first edge. The bench models the ROM as an array indexed directly by `rom_addr`. It drives flags and the request only at falling edges, changing them only in phases where the sequencer does not sample them. Programs are built so that every path reaches a known fetch address; stack overrun is the one case that is provoked on purpose.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [2:0] {
        ST_RST   = 3'd0,
        ST_FETCH = 3'd1,
        ST_DEC   = 3'd2,
        ST_EXEC  = 3'd3,
        ST_WAIT  = 3'd4,
        ST_INTR  = 3'd5,
        ST_IJMP  = 3'd6
    } mcs_state_e;

    localparam int IW     = 17;
    localparam int TGT_W  = 13;
    localparam int OPC_W  = 5;

    localparam logic [1:0] BR_ZERO  = 2'b00;
    localparam logic [1:0] BR_CARRY = 2'b01;
    localparam logic [1:0] BR_ALWAYS = 2'b10;

    localparam logic [4:0] OPC_PUT  = 5'b11000;
    localparam logic [4:0] OPC_RET  = 5'b11001;
    localparam logic [4:0] OPC_PIN  = 5'b11010;
    localparam logic [4:0] OPC_POUT = 5'b11011;
    localparam logic [4:0] OPC_IEON = 5'b11100;
    localparam logic [4:0] OPC_IEOFF = 5'b11101;
    localparam logic [4:0] OPC_IRET = 5'b11110;
    localparam logic [4:0] OPC_JREL = 5'b11111;

    function automatic logic uses_datapath(input logic [4:0] opc);
        return (!opc[4]) || (opc == OPC_PUT) || (opc == OPC_PIN) || (opc == OPC_POUT);
    endfunction

    function automatic logic is_branch(input logic [4:0] opc);
        return opc[4:3] == 2'b10;
    endfunction

endpackage

// File: rtl/mcs_phase_fsm.sv
module mcs_phase_fsm
    import mcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_take,
    output mcs_state_e state
);

    typedef struct packed {
        mcs_state_e st;
        logic       rst_cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_RST: begin
                if (fsm_q.rst_cnt) begin
                    fsm_d.st      = ST_FETCH;
                    fsm_d.rst_cnt = 1'b0;
                end else begin
                    fsm_d.rst_cnt = 1'b1;
                end
            end
            ST_FETCH: fsm_d.st = ST_DEC;
            ST_DEC:   fsm_d.st = ST_EXEC;
            ST_EXEC:  fsm_d.st = ST_WAIT;
            ST_WAIT:  fsm_d.st = irq_take ? ST_INTR : ST_FETCH;
            ST_INTR:  fsm_d.st = ST_IJMP;
            ST_IJMP:  fsm_d.st = ST_FETCH;
            default:  fsm_d.st = ST_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_RST, rst_cnt: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.st;

    // R2
    fetch_to_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_DEC));
    // R2
    dec_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEC) |=> (state == ST_EXEC));
    // R2
    exec_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |=> (state == ST_WAIT));
    // R9
    intr_to_ijmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTR) |=> (state == ST_IJMP));
    // R1
    rst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST) |=> (state == ST_RST || state == ST_FETCH));

endmodule

// File: rtl/mcs_ret_stack.sv
module mcs_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] pop_data,
    output logic         err
);

    localparam int SP_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [SP_W-1:0]         sp;
        logic [SP_W:0]           cnt;
        logic                    err;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [SP_W-1:0] rd_idx;

    assign rd_idx   = stk_q.sp - 1'b1;
    assign pop_data = stk_q.mem[rd_idx];
    assign err      = stk_q.err;

    always_comb begin
        stk_d = stk_q;
        if (push) begin
            stk_d.mem[stk_q.sp] = push_data;
            stk_d.sp            = stk_q.sp + 1'b1;
            if (stk_q.cnt == (SP_W+1)'(DEPTH)) begin
                stk_d.err = 1'b1;
            end else begin
                stk_d.cnt = stk_q.cnt + 1'b1;
            end
        end else if (pop) begin
            stk_d.sp = rd_idx;
            if (stk_q.cnt == '0) begin
                stk_d.err = 1'b1;
            end else begin
                stk_d.cnt = stk_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.cnt <= (SP_W+1)'(DEPTH));
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R11
    no_dual_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
    import mcs_pkg::*;
#(
    parameter int ROM_DEPTH = 256,
    parameter int INT_VEC   = 1,
    parameter int STK_DEPTH = 8,
    localparam int PC_W     = $clog2(ROM_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_req,
    input  logic [16:0]     instr_word,
    input  logic            zero_flag,
    input  logic            carry_flag,
    output logic [PC_W-1:0] rom_addr,
    output logic [16:0]     ir_q,
    output logic            ir_load,
    output logic            dp_en,
    output logic            acc_clr,
    output logic            carry_wr_en,
    output logic            carry_wr_val,
    output logic            int_en,
    output logic            stk_err,
    output logic [2:0]      ctl_state
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [IW-1:0]   ir;
        logic            int_en;
        logic            carry_sv;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    mcs_state_e state;

    logic             stk_push, stk_pop;
    logic [TGT_W-1:0] stk_dout;
    logic [TGT_W-1:0] stk_din;
    logic [4:0]       opc;
    logic [7:0]       gen;
    logic [PC_W-1:0]  tgt;

    assign opc     = ctl_q.ir[16:12];
    assign gen     = ctl_q.ir[11:4];
    assign tgt     = ctl_q.ir[PC_W-1:0];
    assign stk_din = TGT_W'(ctl_q.pc);

    mcs_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_take (irq_req && ctl_q.int_en),
        .state    (state)
    );

    mcs_ret_stack #(
        .DEPTH (STK_DEPTH),
        .W     (TGT_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (stk_din),
        .pop_data  (stk_dout),
        .err       (stk_err)
    );

    always_comb begin
        ctl_d    = ctl_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        unique case (state)
            ST_RST: begin
                ctl_d = '0;
            end
            ST_FETCH: begin
                ctl_d.ir = instr_word;
                ctl_d.pc = ctl_q.pc + 1'b1;
            end
            ST_EXEC: begin
                if (is_branch(opc)) begin
                    unique case (opc[2:1])
                        BR_ZERO:   if (zero_flag)  ctl_d.pc = tgt;
                        BR_CARRY:  if (carry_flag) ctl_d.pc = tgt;
                        BR_ALWAYS: ctl_d.pc = tgt;
                        default: begin
                            ctl_d.pc = tgt;
                            stk_push = 1'b1;
                        end
                    endcase
                end else begin
                    unique case (opc)
                        OPC_RET: begin
                            stk_pop  = 1'b1;
                            ctl_d.pc = stk_dout[PC_W-1:0];
                        end
                        OPC_IRET: begin
                            stk_pop      = 1'b1;
                            ctl_d.pc     = stk_dout[PC_W-1:0];
                            ctl_d.int_en = 1'b1;
                        end
                        OPC_IEON:  ctl_d.int_en = 1'b1;
                        OPC_IEOFF: ctl_d.int_en = 1'b0;
                        OPC_JREL:  ctl_d.pc = ctl_q.pc + PC_W'(gen);
                        default: ;
                    endcase
                end
            end
            ST_INTR: begin
                stk_push       = 1'b1;
                ctl_d.int_en   = 1'b0;
                ctl_d.carry_sv = carry_flag;
            end
            ST_IJMP: begin
                ctl_d.pc = PC_W'(INT_VEC);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rom_addr     = ctl_q.pc;
    assign ir_q         = ctl_q.ir;
    assign ir_load      = (state == ST_FETCH);
    assign dp_en        = (state == ST_DEC || state == ST_EXEC) && uses_datapath(opc);
    assign acc_clr      = (state == ST_RST);
    assign carry_wr_en  = (state == ST_EXEC) && (opc == OPC_IRET);
    assign carry_wr_val = ctl_q.carry_sv;
    assign int_en       = ctl_q.int_en;
    assign ctl_state    = state;

    // R3
    dp_en_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_en |-> (state == ST_DEC || state == ST_EXEC));
    // R3
    dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEC && dp_en) |=> dp_en);
    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEC) |=> $stable(rom_addr));
    // R9
    ijmp_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IJMP) |=> (rom_addr == PC_W'(INT_VEC)));
    // R9
    intr_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTR) |=> !int_en);
    // R10
    restore_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_wr_en |=> (state == ST_WAIT && int_en));

endmodule

// File: tb/mcs_sequencer_tb.sv
module mcs_sequencer_tb;

    localparam int DEPTH = 256;
    localparam int VEC   = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic        zero_flag = 1'b0;
    logic        carry_flag = 1'b0;
    logic [16:0] instr_word;
    logic [7:0]  rom_addr;
    logic [16:0] ir_q;
    logic        ir_load, dp_en, acc_clr, carry_wr_en, carry_wr_val, int_en, stk_err;
    logic [2:0]  ctl_state;

    logic [16:0] rom [DEPTH];
    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign instr_word = rom[rom_addr];

    mcs_sequencer #(.ROM_DEPTH(DEPTH), .INT_VEC(VEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_word(instr_word),
        .zero_flag(zero_flag), .carry_flag(carry_flag), .rom_addr(rom_addr),
        .ir_q(ir_q), .ir_load(ir_load), .dp_en(dp_en), .acc_clr(acc_clr),
        .carry_wr_en(carry_wr_en), .carry_wr_val(carry_wr_val), .int_en(int_en),
        .stk_err(stk_err), .ctl_state(ctl_state)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_rom();
        for (int i = 0; i < DEPTH; i++) rom[i] = 17'h0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic wait_state(input int s);
        for (int i = 0; i < 40; i++) begin
            if (int'(ctl_state) == s) break;
            step();
        end
    endtask

    task automatic wait_fetch(output int a);
        wait_state(1);
        a = int'(rom_addr);
        step();
    endtask

    function automatic logic [16:0] br(input logic [3:0] op, input int t);
        return {op, 13'(t)};
    endfunction

    function automatic logic [16:0] ctl(input logic [4:0] op, input int g);
        return {op, 8'(g), 4'h0};
    endfunction

    initial begin
        int a;
        int exp;
        clear_rom();
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) step();
        chk(ctl_state == 3'd0, "R1 state in reset", int'(ctl_state), 0);
        chk(rom_addr == 8'd0, "R1 rom_addr in reset", int'(rom_addr), 0);
        chk(acc_clr == 1'b1, "R1 acc_clr in reset", int'(acc_clr), 1);
        chk(int_en == 1'b0 && stk_err == 1'b0, "R1 ie/err in reset", int'({int_en, stk_err}), 0);
        rst_n = 1'b1;
        step();
        chk(ctl_state == 3'd0, "R1 second reset phase", int'(ctl_state), 0);
        step();
        chk(ctl_state == 3'd1 && rom_addr == 8'd0, "R1 first fetch", int'(ctl_state), 1);

        // R2: phase sequence and increment
        rom[0] = 17'h0_1234;
        chk(ir_load == 1'b1, "R2 ir_load in fetch", int'(ir_load), 1);
        step();
        chk(ctl_state == 3'd2 && ir_load == 1'b0, "R2 decode", int'(ctl_state), 2);
        chk(ir_q == 17'h0_1234, "R2 ir captured", int'(ir_q), 'h1234);
        chk(rom_addr == 8'd1, "R2 pc advanced", int'(rom_addr), 1);
        step();
        chk(ctl_state == 3'd3, "R2 execute", int'(ctl_state), 3);
        step();
        chk(ctl_state == 3'd4, "R2 wait", int'(ctl_state), 4);
        step();
        chk(ctl_state == 3'd1 && rom_addr == 8'd1, "R2 next fetch", int'(rom_addr), 1);

        // R3: datapath enable over all opcodes
        for (int op = 0; op < 32; op++) begin
            clear_rom();
            rom[0] = ctl(5'(op), 0);
            do_reset();
            exp = (op < 16 || op == 24 || op == 26 || op == 27) ? 1 : 0;
            wait_state(1);
            chk(dp_en == 1'b0, "R3 dp_en low in fetch", int'(dp_en), 0);
            step();
            chk(int'(dp_en) == exp, "R3 dp_en decode", int'(dp_en), exp);
            step();
            chk(int'(dp_en) == exp, "R3 dp_en execute", int'(dp_en), exp);
            step();
            chk(dp_en == 1'b0, "R3 dp_en low in wait", int'(dp_en), 0);
        end

        // R4 R5: conditional and unconditional branches over flag combinations
        for (int k = 0; k < 3; k++) begin
            for (int f = 0; f < 4; f++) begin
                clear_rom();
                rom[0] = br(4'(8 + k), 'h40);
                zero_flag = f[0];
                carry_flag = f[1];
                do_reset();
                wait_fetch(a);
                wait_fetch(a);
                exp = (k == 2 || (k == 0 && f[0]) || (k == 1 && f[1])) ? 'h40 : 1;
                chk(a == exp, (k == 2) ? "R5 jump" : "R4 cond jump", a, exp);
            end
        end
        zero_flag = 1'b0;
        carry_flag = 1'b0;

        // R6: call and return
        clear_rom();
        rom[0] = br(4'b1011, 'h30);
        rom['h30] = ctl(5'b11001, 0);
        do_reset();
        wait_fetch(a);
        wait_fetch(a);
        chk(a == 'h30, "R6 call target", a, 'h30);
        wait_fetch(a);
        chk(a == 1, "R6 return address", a, 1);
        chk(stk_err == 1'b0, "R6 no stack error", int'(stk_err), 0);

        // R7: relative jump sweep, including wrap
        for (int g = 0; g < 256; g += 17) begin
            clear_rom();
            rom[0] = ctl(5'b11111, g);
            do_reset();
            wait_fetch(a);
            wait_fetch(a);
            exp = (1 + g) % DEPTH;
            chk(a == exp, "R7 relative jump", a, exp);
        end
        clear_rom();
        rom[0] = ctl(5'b11111, 'hFF);
        do_reset();
        wait_fetch(a);
        wait_fetch(a);
        chk(a == 0, "R7 relative jump wrap", a, 0);

        // R2: program counter wraps at the top of ROM
        clear_rom();
        rom[0] = br(4'b1010, 'hFF);
        do_reset();
        wait_fetch(a);
        wait_fetch(a);
        wait_fetch(a);
        chk(a == 0, "R2 pc wrap", a, 0);

        // R9: request ignored while disabled
        clear_rom();
        irq_req = 1'b1;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            wait_fetch(a);
            chk(a == i, "R9 irq ignored when disabled", a, i);
        end
        irq_req = 1'b0;

        // R8 R9 R10: enable, entry, carry capture and return
        clear_rom();
        rom[0] = ctl(5'b11100, 0);
        rom[VEC] = ctl(5'b11110, 0);
        carry_flag = 1'b1;
        irq_req = 1'b1;
        do_reset();
        wait_fetch(a);
        wait_state(4);
        chk(int_en == 1'b1, "R8 enable set", int'(int_en), 1);
        step();
        chk(ctl_state == 3'd5, "R9 interrupt phase", int'(ctl_state), 5);
        step();
        chk(ctl_state == 3'd6, "R9 vector phase", int'(ctl_state), 6);
        chk(int_en == 1'b0, "R9 enable cleared on entry", int'(int_en), 0);
        carry_flag = 1'b0;
        irq_req = 1'b0;
        step();
        chk(ctl_state == 3'd1 && rom_addr == 8'(VEC), "R9 fetch at vector", int'(rom_addr), VEC);
        wait_state(3);
        chk(carry_wr_en == 1'b1 && carry_wr_val == 1'b1, "R10 carry restore", int'({carry_wr_en, carry_wr_val}), 3);
        step();
        chk(int_en == 1'b1, "R10 enable restored", int'(int_en), 1);
        wait_fetch(a);
        chk(a == 1, "R10 return to interrupted flow", a, 1);

        // R10: capture of a zero carry
        clear_rom();
        rom[0] = ctl(5'b11100, 0);
        rom[VEC] = ctl(5'b11110, 0);
        carry_flag = 1'b0;
        irq_req = 1'b1;
        do_reset();
        wait_state(6);
        carry_flag = 1'b1;
        irq_req = 1'b0;
        wait_state(3);
        chk(carry_wr_en == 1'b1 && carry_wr_val == 1'b0, "R10 carry zero restore", int'({carry_wr_en, carry_wr_val}), 2);
        carry_flag = 1'b0;

        // R8: disable blocks a later request
        clear_rom();
        rom[0] = ctl(5'b11100, 0);
        rom[1] = ctl(5'b11101, 0);
        do_reset();
        wait_fetch(a);
        wait_fetch(a);
        wait_state(4);
        chk(int_en == 1'b0, "R8 enable cleared", int'(int_en), 0);
        irq_req = 1'b1;
        wait_fetch(a);
        chk(a == 2, "R8 no entry after disable", a, 2);
        irq_req = 1'b0;

        // R11: overflow after nine calls
        clear_rom();
        for (int i = 0; i < 9; i++) rom[i] = br(4'b1011, i + 1);
        rom[9] = ctl(5'b11001, 0);
        do_reset();
        for (int i = 0; i < 9; i++) begin
            wait_fetch(a);
            if (i == 8) chk(stk_err == 1'b0, "R11 no error at eight", int'(stk_err), 0);
        end
        wait_fetch(a);
        chk(a == 9, "R11 ninth call target", a, 9);
        chk(stk_err == 1'b1, "R11 overflow flagged", int'(stk_err), 1);
        wait_fetch(a);
        chk(a == 9, "R11 wrapped return value", a, 9);

        // R11: underflow, then reset clears the flag
        clear_rom();
        rom[0] = ctl(5'b11001, 0);
        do_reset();
        wait_fetch(a);
        chk(stk_err == 1'b0, "R11 clear before pop", int'(stk_err), 0);
        wait_state(4);
        chk(stk_err == 1'b1, "R11 underflow flagged", int'(stk_err), 1);
        rst_n = 1'b0;
        step();
        chk(stk_err == 1'b0, "R1 reset clears stack error", int'(stk_err), 0);

        summary();
        $finish;
    end

endmodule